// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. A slow reference clock arrives as a one-cycle enable pulse, `ref_tick`, in the system clock domain. A programmable prescaler divides that pulse train. Each prescaler wrap decrements a 16-bit down-counter. When the counter runs out while counting is enabled, the block raises a one-cycle reset request. After that the counter stays idle until software reloads it.

Every bus write must carry the 16-bit key 0x1234 in its upper half-word. A write without the key is thrown away. Writing the divisor or the load value does not touch the running logic directly. The write only updates a pending copy. Software then commits the copy by flipping a two-bit group in the refresh register between the values 1 and 2. The refresh register can be read, so one read, an XOR with 0x3F and one write-back flip all three groups at once.

Top module: `keyed_wdog`

## Requirements
- R1: A write is accepted only when `bus_wdata[31:16]` equals 0x1234; any other upper half leaves every register and the running state untouched.
- R2: Reads are combinational on `bus_addr`. Bits 31:16 always read 0. The registers are: pending divisor-minus-one at offset 0x04 (bits 15:8), pending load value at 0x08 (bits 15:0), refresh at 0x18 (bits 5:0), start at 0x1C (bit 0). Any other offset reads 0.
- R3: After reset, offset 0x04 reads 0x0F00 and the active divisor is 16. Offset 0x08 reads 0xFFFF, the refresh register reads 0x15, start reads 0, the counter holds 0xFFFF and `rst_req` is low.
- R4: The refresh register has three groups: bits 5:4 (config), bits 3:2 (counter) and bits 1:0 (third value). A group changes only when a keyed write moves it from 1 to 2 or from 2 to 1. Writing its current value, 0 or 3 leaves it unchanged.
- R5: A newly written load value has no effect on counting until the counter group (bits 3:2) flips. The flip copies the pending load value into the counter, clears the expired state and restarts the prescaler phase.
- R6: A newly written divisor has no effect until the config group (bits 5:4) flips. The flip makes the active divisor equal to pending bits 15:8 plus one and restarts the prescaler phase.
- R7: With start bit 0 at 1, `rst_req` rises exactly after load × divisor reference ticks have been counted since the last reload.
- R8: `rst_req` is high for exactly one cycle per expiry. After an expiry no further request is made, whatever the number of ticks, until a counter-group flip reloads the counter.
- R9: With start bit 0 at 0, the counter and the prescaler phase hold their values. Setting the bit again resumes counting from where it stopped.
- R10: A flip of the third group (bits 1:0) alone neither reloads nor changes the counter or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data: key in 31:16, value in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Expiry time is measured in reference ticks across several input patterns. One pattern uses the default divisor. Another uses a randomly drawn set of load and divisor pairs committed in a single refresh write; these check the count × divisor product itself. Directed patterns change the load or the divisor without the matching flip, flip only the third group, or stop and restart the counter partway through. Each of these gives a tick count that differs from the committed-value expectation if a pending value leaks through early, a wrong group commits, or the prescaler phase is lost. Keyed, unkeyed and illegal refresh writes are told apart by reading the registers back.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned ADDR_W = 5;
    localparam logic [HALF_W-1:0] WR_KEY = 16'h1234;

    localparam logic [ADDR_W-1:0] A_CFG   = 5'h04;
    localparam logic [ADDR_W-1:0] A_LOAD  = 5'h08;
    localparam logic [ADDR_W-1:0] A_REFR  = 5'h18;
    localparam logic [ADDR_W-1:0] A_START = 5'h1C;

    localparam int unsigned N_GRP  = 3;
    localparam int unsigned GRP_W  = 2;
    localparam int unsigned REFR_W = N_GRP * GRP_W;
    localparam int unsigned G_AUX  = 0;
    localparam int unsigned G_CNT  = 1;
    localparam int unsigned G_CFG  = 2;

    localparam logic [GRP_W-1:0] PH_A = 2'd1;
    localparam logic [GRP_W-1:0] PH_B = 2'd2;

    function automatic logic is_flip(logic [GRP_W-1:0] cur, logic [GRP_W-1:0] nxt);
        return ((cur == PH_A) && (nxt == PH_B)) || ((cur == PH_B) && (nxt == PH_A));
    endfunction
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned DIV_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [DIV_W-1:0]  div_m1_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              run_en_o,
    output logic              reload_o,
    output logic              cfg_commit_o
);
    typedef struct packed {
        logic [DIV_W-1:0]  div_sh;
        logic [DIV_W-1:0]  div_act;
        logic [CNT_W-1:0]  load_sh;
        logic [REFR_W-1:0] refr;
        logic              run_en;
    } regs_t;

    regs_t q, d;

    logic              key_ok;
    logic              wr_ok;
    logic [HALF_W-1:0] val;
    logic [N_GRP-1:0]  flip;
    logic [HALF_W-1:0] rd16;

    assign key_ok = (bus_wdata[BUS_W-1:HALF_W] == WR_KEY);
    assign wr_ok  = bus_wr && key_ok;
    assign val    = bus_wdata[HALF_W-1:0];

    for (genvar g = 0; g < N_GRP; g++) begin : g_flip
        assign flip[g] = wr_ok && (bus_addr == A_REFR) &&
                         is_flip(q.refr[g*GRP_W +: GRP_W], val[g*GRP_W +: GRP_W]);
    end

    always_comb begin
        d = q;
        if (wr_ok) begin
            case (bus_addr)
                A_CFG:   d.div_sh  = val[8 +: DIV_W];
                A_LOAD:  d.load_sh = val[CNT_W-1:0];
                A_START: d.run_en  = val[0];
                A_REFR: begin
                    for (int g = 0; g < N_GRP; g++) begin
                        if (flip[g]) d.refr[g*GRP_W +: GRP_W] = val[g*GRP_W +: GRP_W];
                    end
                end
                default: ;
            endcase
        end
        if (flip[G_CFG]) d.div_act = q.div_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{div_sh:  DIV_W'(DIV_RST - 1),
                   div_act: DIV_W'(DIV_RST - 1),
                   load_sh: '1,
                   refr:    {N_GRP{PH_A}},
                   run_en:  1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CFG:   rd16 = HALF_W'(q.div_sh) << 8;
            A_LOAD:  rd16 = HALF_W'(q.load_sh);
            A_REFR:  rd16 = HALF_W'(q.refr);
            A_START: rd16 = HALF_W'(q.run_en);
            default: rd16 = '0;
        endcase
    end

    assign bus_rdata    = {{(BUS_W-HALF_W){1'b0}}, rd16};
    assign div_m1_o     = q.div_act;
    assign load_o       = q.load_sh;
    assign run_en_o     = q.run_en;
    assign reload_o     = flip[G_CNT];
    assign cfg_commit_o = flip[G_CFG];
endmodule

// File: rtl/keyed_wdog_presc.sv
module keyed_wdog_presc #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             dec_o
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } presc_t;

    presc_t q, d;
    logic   step;
    logic   wrap;

    assign step  = tick_i && run_i && !clear_i;
    assign wrap  = (q.phase >= div_m1_i);
    assign dec_o = step && wrap;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.phase = '0;
        end else if (step) begin
            d.phase = wrap ? '0 : q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: '0};
        else        q <= d;
    end
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             halted_o,
    output logic             rst_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             halted;
        logic             req;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (reload_i) begin
            d.cnt    = load_i;
            d.halted = 1'b0;
        end else if (dec_i && !q.halted) begin
            if (q.cnt <= CNT_W'(1)) begin
                d.cnt    = '0;
                d.halted = 1'b1;
                d.req    = 1'b1;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '1, halted: 1'b0, req: 1'b0};
        else        q <= d;
    end

    assign cnt_o     = q.cnt;
    assign halted_o  = q.halted;
    assign rst_req_o = q.req;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned DIV_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              rst_req
);
    logic [DIV_W-1:0] div_w;
    logic [CNT_W-1:0] load_w;
    logic [CNT_W-1:0] cnt_w;
    logic             run_en_w;
    logic             reload_w;
    logic             commit_w;
    logic             halted_w;
    logic             run_w;
    logic             dec_w;

    keyed_wdog_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .div_m1_o     (div_w),
        .load_o       (load_w),
        .run_en_o     (run_en_w),
        .reload_o     (reload_w),
        .cfg_commit_o (commit_w)
    );

    assign run_w = run_en_w && !halted_w;

    keyed_wdog_presc #(.DIV_W(DIV_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (ref_tick),
        .run_i    (run_w),
        .clear_i  (reload_w || commit_w),
        .div_m1_i (div_w),
        .dec_o    (dec_w)
    );

    keyed_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec_w),
        .reload_i  (reload_w),
        .load_i    (load_w),
        .cnt_o     (cnt_w),
        .halted_o  (halted_w),
        .rst_req_o (rst_req)
    );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [CNT_W-1:0]  load_w,
    input logic [DIV_W-1:0]  div_w,
    input logic              halted_w,
    input logic              run_w,
    input logic              reload_w
);
    // R8
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    req_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt_w == '0) && halted_w);

    // R1
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_wdata[BUS_W-1:HALF_W] != WR_KEY)) |=>
        ($stable(load_w) && $stable(div_w)));

    // R4
    grp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_REFR) |->
        ((bus_rdata[1:0] == PH_A || bus_rdata[1:0] == PH_B) &&
         (bus_rdata[3:2] == PH_A || bus_rdata[3:2] == PH_B) &&
         (bus_rdata[5:4] == PH_A || bus_rdata[5:4] == PH_B)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !reload_w) |=> $stable(cnt_w));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_w |=> ((cnt_w == $past(cnt_w)) ||
                       (cnt_w == $past(cnt_w) - CNT_W'(1)) ||
                       (cnt_w == '0)));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .cnt_w     (cnt_w),
    .load_w    (load_w),
    .div_w     (div_w),
    .halted_w  (halted_w),
    .run_w     (run_w),
    .reload_w  (reload_w)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    logic [5:0] refr_m = 6'h15;
    bit done = 0;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_ticks(int ld, int dv);
        return ld * dv;
    endfunction

    function automatic logic [5:0] flipped(logic [5:0] cur, logic [2:0] mask);
        logic [5:0] r = cur;
        for (int g = 0; g < 3; g++) if (mask[g]) r[g*2 +: 2] = cur[g*2 +: 2] ^ 2'b11;
        return r;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] key, logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = {key, v};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic flip(logic [2:0] mask);
        refr_m = flipped(refr_m, mask);
        wr(5'h18, 16'h1234, {10'h0, refr_m});
    endtask

    task automatic measure(int limit, output int hit);
        hit = 0;
        for (int i = 1; i <= limit && hit == 0; i++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
            if (rst_req) hit = i;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hit;
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 / R2: reset values and zero upper half
        rd(5'h04, v); chk("R3 cfg", v, 32'h0000_0F00);
        rd(5'h08, v); chk("R3 load", v, 32'h0000_FFFF);
        rd(5'h18, v); chk("R3 refresh", v, 32'h0000_0015);
        rd(5'h1C, v); chk("R3 start", v, 32'h0);
        rd(5'h10, v); chk("R2 unmapped", v, 32'h0);
        chk("R3 rst_req", rst_req, 0);

        // R1: key gating
        wr(5'h08, 16'h1235, 16'h0003);
        rd(5'h08, v); chk("R1 bad key load", v, 32'h0000_FFFF);
        wr(5'h08, 16'h1234, 16'h0003);
        rd(5'h08, v); chk("R1 good key load", v, 32'h0000_0003);
        wr(5'h1C, 16'h0000, 16'h0001);
        rd(5'h1C, v); chk("R1 bad key start", v, 32'h0);
        wr(5'h18, 16'hFFFF, 16'h002A);
        rd(5'h18, v); chk("R1 bad key refresh", v, 32'h15);

        // R4: refresh group legality
        wr(5'h18, 16'h1234, 16'h0000);
        rd(5'h18, v); chk("R4 zero write", v, 32'h15);
        wr(5'h18, 16'h1234, 16'h003F);
        rd(5'h18, v); chk("R4 three write", v, 32'h15);
        wr(5'h18, 16'h1234, 16'h0015);
        rd(5'h18, v); chk("R4 same write", v, 32'h15);
        flip(3'b111);
        rd(5'h18, v); chk("R4 all flip", v, 32'h2A);
        flip(3'b101);
        rd(5'h18, v); chk("R4 mixed flip", v, 32'h19);

        // R7: default divisor 16, load 5
        wr(5'h08, 16'h1234, 16'd5);
        flip(3'b010);
        wr(5'h1C, 16'h1234, 16'h0001);
        measure(100, hit); chk("R7 div16 ticks", hit, exp_ticks(5, 16));
        // R8: one-cycle request, then stay idle
        @(negedge clk); chk("R8 one cycle", rst_req, 0);
        measure(60, hit); chk("R8 idle after expiry", hit, 0);
        flip(3'b010);
        measure(100, hit); chk("R8 reload restarts", hit, exp_ticks(5, 16));

        // R5: pending load ignored until counter group flips
        wr(5'h04, 16'h1234, 16'h0000);
        wr(5'h08, 16'h1234, 16'd4);
        flip(3'b110);
        measure(2, hit); chk("R5 early", hit, 0);
        wr(5'h08, 16'h1234, 16'd10);
        measure(10, hit); chk("R5 old load used", hit, 2);
        flip(3'b010);
        measure(20, hit); chk("R5 new load after flip", hit, 10);

        // R10: third group flip does not reload
        wr(5'h08, 16'h1234, 16'd6);
        flip(3'b010);
        measure(2, hit); chk("R10 early", hit, 0);
        flip(3'b001);
        measure(10, hit); chk("R10 no reload", hit, 4);

        // R9: stop holds counter and prescaler phase
        wr(5'h04, 16'h1234, 16'h0100);
        flip(3'b110);
        measure(5, hit); chk("R9 before stop", hit, 0);
        wr(5'h1C, 16'h1234, 16'h0000);
        measure(40, hit); chk("R9 stopped", hit, 0);
        wr(5'h1C, 16'h1234, 16'h0001);
        measure(20, hit); chk("R9 resume remainder", hit, 7);

        // R6: pending divisor ignored until config group flips
        wr(5'h04, 16'h1234, 16'h0300);
        wr(5'h08, 16'h1234, 16'd3);
        flip(3'b010);
        measure(30, hit); chk("R6 old divisor", hit, exp_ticks(3, 2));
        flip(3'b100);
        flip(3'b010);
        measure(30, hit); chk("R6 new divisor", hit, exp_ticks(3, 4));

        // R7: random load / divisor pairs
        for (int it = 0; it < 16; it++) begin
            int ld = 1 + int'($urandom % 6);
            int dv = 1 + int'($urandom % 6);
            wr(5'h04, 16'h1234, 16'((dv - 1) << 8));
            wr(5'h08, 16'h1234, 16'(ld));
            flip(3'b110);
            measure(exp_ticks(ld, dv) + 4, hit);
            chk("R7 random ticks", hit, exp_ticks(ld, dv));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule